// File: doc/BRIEF.md
# Error-Correcting RAM Wrapper with Address Check

This block puts a single-port synchronous RAM of 32-bit words behind single-error-correct, double-error-detect protection. Each 16-bit half of a word carries its own 7-bit check field. A third 7-bit field is derived from the word's address and stored with it. A read then catches a word that arrived from the wrong location.

The CPU side issues 16-bit or 32-bit reads and writes. A read is accepted in one cycle. In the next cycle the block presents corrected data together with the correctable and uncorrectable flags and the address of the failing word. Correction adds no wait state. The uncorrectable flag is meant to drive a non-maskable interrupt. Error counting and interrupt policy sit outside the block.

After reset a sequencer fills every location with zero data and matching check fields. It then raises `init_done`. The CPU is held off until then. A write-side flip mask lets a test corrupt any stored bit on purpose.

Top module: `ecc_ram_wrap`

## Requirements
- R1: After reset `ready` and `init_done` are 0. `init_done` rises after the sequencer has written every word once and stays high. Any word read afterwards without an intervening write returns 0 with no error flag.
- R2: A 32-bit write (`size`=1) followed by a 32-bit read of the same address returns the written data with `rvalid`=1. The result appears in the cycle after the read is accepted, with no error flag.
- R3: A 16-bit write (`size`=0) changes only the half selected by `half`: 0 selects bits 15:0 and 1 selects bits 31:16. The other half keeps its earlier value.
- R4: A 16-bit read returns the selected half on `rdata[15:0]` with `rdata[31:16]`=0. Only that half's check field and the address field are judged, so a fault in the other half raises no flag.
- R5: `wr_flip` is XORed into the stored word on a write. Its layout is: bits 31:0 for data, 38:32 for the low check field, 45:39 for the high check field and 52:46 for the address field. Within a field, bit 6 is a spare that reads ignore, so flipping a spare bit raises no flag. A single flipped bit in a judged half's data or in bits 5:0 of its check field gives corrected data, `err_ce`=1, `err_ue`=0 and `err_addr` equal to the read address.
- R6: Two flipped data bits within one judged half give `err_ue`=1, `err_ce`=0 and `err_addr` equal to the read address.
- R7: A flip in bits 51:46 always gives `err_ue`=1 and never `err_ce`, even when the data is intact.
- R8: Single errors in both halves of one 32-bit read give one read result with `err_ce`=1, `err_ue`=0 and both halves corrected.
- R9: When one half is uncorrectable and the other correctable in the same read, only `err_ue` is raised.
- R10: While `init_done` is 0, requests are refused: `ready`=0 and no `rvalid` follows a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| half | input | 1 | Half for a 16-bit access (0 low, 1 high) |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data (a 16-bit write uses the half's bit lane) |
| wr_flip | input | 53 | XOR mask applied to the stored word on write |
| ready | output | 1 | Requests are accepted |
| init_done | output | 1 | Initialization finished |
| rvalid | output | 1 | Read result valid this cycle |
| rdata | output | 32 | Corrected read data |
| err_ce | output | 1 | Corrected error on this read |
| err_ue | output | 1 | Uncorrectable error on this read |
| err_addr | output | ADDR_W | Address of the failing read, 0 when no flag |

## Verification
The two checks that can land on the same read are correction in one half and detection in the other half or in the address field. The bench plants single flips in both halves, a double flip beside a single flip, and an address-field flip beside intact data. It requires exactly one flag: correctable only when nothing is uncorrectable, and uncorrectable whenever any judged field is. The returned data must still match the written value in every half that was correctable.

// File: rtl/ecc_ram_wrap.sv
module ecc_ram_wrap #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              size,
  input  logic              half,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [52:0]       wr_flip,
  output logic              ready,
  output logic              init_done,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              err_ce,
  output logic              err_ue,
  output logic [ADDR_W-1:0] err_addr
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [6:0] enc16(input logic [15:0] d);
    logic [4:0] p;
    int j;
    p = 5'd0;
    j = 0;
    for (int pos = 1; pos < 22; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[j]) p = p ^ pos[4:0];
        j++;
      end
    end
    return {1'b1, ^{d, p}, p};
  endfunction

  function automatic logic [15:0] fix16(input logic [15:0] d, input logic [4:0] syn);
    logic [15:0] r;
    int j;
    r = d;
    j = 0;
    for (int pos = 1; pos < 22; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (syn == pos[4:0]) r[j] = ~r[j];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] a16(input logic [ADDR_W-1:0] a);
    logic [15:0] r;
    r = '0;
    r[ADDR_W-1:0] = a;
    return r;
  endfunction

  logic [52:0]       mem [DEPTH];
  logic [52:0]       rd_q;
  logic [ADDR_W-1:0] icnt, rd_addr;
  logic              rd_size, rd_half;

  assign ready = init_done;
  wire acc = req && init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt      <= '0;
      init_done <= 1'b0;
      rvalid    <= 1'b0;
      rd_addr   <= '0;
      rd_size   <= 1'b0;
      rd_half   <= 1'b0;
    end else begin
      if (!init_done) begin
        icnt <= icnt + 1'b1;
        if (icnt == ADDR_W'(DEPTH - 1)) init_done <= 1'b1;
      end
      rvalid <= acc && !we;
      if (acc && !we) begin
        rd_addr <= addr;
        rd_size <= size;
        rd_half <= half;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!init_done) begin
      mem[icnt] <= {enc16(a16(icnt)), enc16(16'h0), enc16(16'h0), 32'h0};
    end else if (acc && we) begin
      if (size || !half) begin
        mem[addr][15:0]  <= wdata[15:0] ^ wr_flip[15:0];
        mem[addr][38:32] <= enc16(wdata[15:0]) ^ wr_flip[38:32];
      end
      if (size || half) begin
        mem[addr][31:16] <= wdata[31:16] ^ wr_flip[31:16];
        mem[addr][45:39] <= enc16(wdata[31:16]) ^ wr_flip[45:39];
      end
      mem[addr][52:46] <= enc16(a16(addr)) ^ wr_flip[52:46];
    end
    if (acc && !we) rd_q <= mem[addr];
  end

  logic [6:0] ck_lo, ck_hi, ck_ad;
  assign ck_lo = enc16(rd_q[15:0]);
  assign ck_hi = enc16(rd_q[31:16]);
  assign ck_ad = enc16(a16(rd_addr));

  wire [4:0] syn_lo = ck_lo[4:0] ^ rd_q[36:32];
  wire [4:0] syn_hi = ck_hi[4:0] ^ rd_q[43:39];
  wire par_lo = ^{rd_q[15:0], rd_q[37:32]};
  wire par_hi = ^{rd_q[31:16], rd_q[44:39]};

  wire ce_lo = par_lo && (syn_lo <= 5'd21);
  wire ce_hi = par_hi && (syn_hi <= 5'd21);
  wire ue_lo = (!par_lo && syn_lo != 5'd0) || (par_lo && syn_lo > 5'd21);
  wire ue_hi = (!par_hi && syn_hi != 5'd0) || (par_hi && syn_hi > 5'd21);
  wire ad_bad = ck_ad[5:0] != rd_q[51:46];

  wire use_lo = rd_size || !rd_half;
  wire use_hi = rd_size || rd_half;

  wire [15:0] fx_lo = fix16(rd_q[15:0], syn_lo);
  wire [15:0] fx_hi = fix16(rd_q[31:16], syn_hi);

  assign err_ue = rvalid && (ad_bad || (use_lo && ue_lo) || (use_hi && ue_hi));
  assign err_ce = rvalid && !err_ue && ((use_lo && ce_lo) || (use_hi && ce_hi));
  assign err_addr = (err_ce || err_ue) ? rd_addr : '0;
  assign rdata = !rvalid ? 32'h0 :
                 rd_size ? {fx_hi, fx_lo} :
                 {16'h0, rd_half ? fx_hi : fx_lo};

  assert_no_read_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> !rvalid);
  assert_done_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_ce && err_ue));
  assert_flags_need_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ce || err_ue) |-> rvalid);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && ready) |=> rvalid);
  assert_half_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rd_size) |-> (rdata[31:16] == 16'h0));
endmodule

// File: tb/ecc_ram_wrap_bench.sv
`timescale 1ns/1ps
module ecc_ram_wrap_bench;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, size = 0, half = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [52:0] wr_flip = '0;
  logic ready, init_done, rvalid, err_ce, err_ue;
  logic [31:0] rdata;
  logic [AW-1:0] err_addr;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  ecc_ram_wrap #(.ADDR_W(AW)) u_ecc_ram_wrap (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .half(half),
    .addr(addr), .wdata(wdata), .wr_flip(wr_flip), .ready(ready),
    .init_done(init_done), .rvalid(rvalid), .rdata(rdata), .err_ce(err_ce),
    .err_ue(err_ue), .err_addr(err_addr));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit sz, input bit h, input logic [52:0] f);
    @(negedge clk);
    req = 1; we = 1; size = sz; half = h; addr = a; wdata = d; wr_flip = f;
    @(negedge clk);
    req = 0; we = 0; wr_flip = '0;
  endtask

  logic [31:0] g_d; logic g_v, g_ce, g_ue; logic [AW-1:0] g_a;
  task automatic rd(input logic [AW-1:0] a, input bit sz, input bit h);
    @(negedge clk);
    req = 1; we = 0; size = sz; half = h; addr = a;
    @(negedge clk);
    req = 0;
    g_d = rdata; g_v = rvalid; g_ce = err_ce; g_ue = err_ue; g_a = err_addr;
  endtask

  task automatic t_reset_init;
    #1;
    chk(ready == 0 && init_done == 0, "R1 reset state", {ready, init_done}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    req = 1; we = 0; size = 1; addr = 5;
    @(negedge clk);
    chk(rvalid == 0 && ready == 0, "R10 request during init refused", {rvalid, ready}, 0);
    req = 0;
    for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
    chk(init_done == 1, "R1 init_done rises", init_done, 1);
    rd(6'd63, 1, 0);
    chk(g_v && g_d == 0 && !g_ce && !g_ue, "R1 initialized word reads clean", {g_v, g_ce, g_ue, g_d}, {3'b100, 32'h0});
    rd(6'd0, 1, 0);
    chk(g_v && g_d == 0 && !g_ce && !g_ue, "R1 word 0 clean", {g_v, g_ce, g_ue, g_d}, {3'b100, 32'h0});
    @(negedge clk);
    chk(init_done == 1, "R1 init_done stays", init_done, 1);
  endtask

  task automatic t_word;
    wr(6'd3, 32'hDEADBEEF, 1, 0, '0);
    rd(6'd3, 1, 0);
    chk(g_v && g_d == 32'hDEADBEEF && !g_ce && !g_ue, "R2 word readback", {g_v, g_ce, g_ue, g_d}, {3'b100, 32'hDEADBEEF});
    wr(6'd4, 32'h0123ABCD, 1, 0, '0);
    rd(6'd4, 1, 0);
    chk(g_d == 32'h0123ABCD && !g_ce && !g_ue, "R2 second pattern", g_d, 32'h0123ABCD);
  endtask

  task automatic t_half;
    wr(6'd5, 32'h11112222, 1, 0, '0);
    wr(6'd5, 32'h0000AAAA, 0, 0, '0);
    rd(6'd5, 1, 0);
    chk(g_d == 32'h1111AAAA && !g_ce && !g_ue, "R3 low half write", g_d, 32'h1111AAAA);
    wr(6'd5, 32'h55550000, 0, 1, '0);
    rd(6'd5, 1, 0);
    chk(g_d == 32'h5555AAAA && !g_ce && !g_ue, "R3 high half write", g_d, 32'h5555AAAA);
    rd(6'd5, 0, 1);
    chk(g_d == 32'h00005555, "R4 half read high", g_d, 32'h00005555);
    rd(6'd5, 0, 0);
    chk(g_d == 32'h0000AAAA, "R4 half read low", g_d, 32'h0000AAAA);
    wr(6'd6, 32'hCAFEF00D, 1, 0, 53'h3 << 16);
    rd(6'd6, 0, 0);
    chk(g_d == 32'h0000F00D && !g_ce && !g_ue, "R4 other-half fault not judged", {g_ce, g_ue, g_d}, {2'b00, 32'h0000F00D});
  endtask

  task automatic t_single;
    wr(6'd7, 32'h89ABCDEF, 1, 0, 53'h1 << 9);
    rd(6'd7, 1, 0);
    chk(g_d == 32'h89ABCDEF && g_ce && !g_ue && g_a == 7, "R5 data bit corrected", {g_ce, g_ue, g_a, g_d}, {2'b10, 6'd7, 32'h89ABCDEF});
    wr(6'd8, 32'h13572468, 1, 0, 53'h1 << 41);
    rd(6'd8, 1, 0);
    chk(g_d == 32'h13572468 && g_ce && !g_ue && g_a == 8, "R5 check bit corrected", {g_ce, g_ue, g_a, g_d}, {2'b10, 6'd8, 32'h13572468});
    wr(6'd9, 32'h2468ACE0, 1, 0, 53'h1 << 38);
    rd(6'd9, 1, 0);
    chk(g_d == 32'h2468ACE0 && !g_ce && !g_ue, "R5 spare bit ignored", {g_ce, g_ue, g_d}, {2'b00, 32'h2468ACE0});
  endtask

  task automatic t_double;
    wr(6'd10, 32'hFFFF0000, 1, 0, 53'h3);
    rd(6'd10, 1, 0);
    chk(g_ue && !g_ce && g_a == 10, "R6 double error flagged", {g_ce, g_ue, g_a}, {2'b01, 6'd10});
    wr(6'd11, 32'h12345678, 1, 0, 53'h1 << 46);
    rd(6'd11, 1, 0);
    chk(g_ue && !g_ce && g_a == 11, "R7 address field fault", {g_ce, g_ue, g_a}, {2'b01, 6'd11});
    wr(6'd12, 32'h12345678, 1, 0, 53'h1 << 51);
    rd(6'd12, 0, 1);
    chk(g_ue && !g_ce, "R7 address fault on half read", {g_ce, g_ue}, 2'b01);
  endtask

  task automatic t_both;
    wr(6'd13, 32'hA5A55A5A, 1, 0, (53'h1 << 20) | (53'h1 << 2));
    rd(6'd13, 1, 0);
    chk(g_d == 32'hA5A55A5A && g_ce && !g_ue && g_a == 13, "R8 two halves corrected", {g_ce, g_ue, g_a, g_d}, {2'b10, 6'd13, 32'hA5A55A5A});
    @(negedge clk);
    chk(!err_ce && !rvalid, "R8 single event", {err_ce, rvalid}, 0);
    wr(6'd14, 32'h0F0FF0F0, 1, 0, (53'h1 << 17) | 53'h5);
    rd(6'd14, 1, 0);
    chk(g_ue && !g_ce, "R9 uncorrectable wins", {g_ce, g_ue}, 2'b01);
    wr(6'd15, 32'h0F0FF0F0, 1, 0, (53'h1 << 48) | 53'h1);
    rd(6'd15, 1, 0);
    chk(g_ue && !g_ce, "R9 address fault beats correction", {g_ce, g_ue}, 2'b01);
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_init();
    t_word();
    t_half();
    t_single();
    t_double();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule